// File: doc/BRIEF.md
# AUX Channel Read Retry Sequencer

This block runs a complete read over an auxiliary display link channel. The caller presents one request: native or I2C-over-AUX address space, an address, a byte length and a flag that keeps the I2C bus held open after the read. The block formats the channel address and action and issues attempts over a request/response handshake. The channel answers each attempt with an outcome, a returned byte count and a reply code. The block sorts each answer into a failure class and keeps one retry counter for each class.

A short acknowledgement does not end the read. The block shrinks the remaining length, moves the offset forward by the bytes delivered and issues the next attempt. An invalid reply waits a configurable number of cycles before the retry. Every other retry goes out at once.

When the read ends, the block raises `done` for one cycle and drives the final status code. The codes are success, NACK, timeout, protocol error, disconnect and unknown. While a read is in flight, `busy` is high and further requests are dropped.

Top module: `aux_rd_seq`

## Requirements
- R1: Channel address and action are formed from the request. Native space (`req_i2c`=0) sends the full address with action 0. I2C space sends the address shifted right by one bit, with action 2 when `req_mot`=1 and action 1 otherwise.
- R2: Outcome 0 (channel ok) with reply 0 (ACK) and a count equal to the remaining length ends the read with status 0 (success). `done` is high for exactly one cycle, and `status` holds the code in that cycle.
- R3: An ACK whose count is below the remaining length reissues at once. The new attempt has offset advanced by the count and length reduced by it. A second such short ACK in the same read ends it with status 3 (protocol error).
- R4: Outcome 0 with a returned count larger than the remaining length ends the read with status 3.
- R5: Reply 1 (NACK) ends the read at once with status 1.
- R6: Outcome 2 (channel timeout) reissues with no wait. The third timeout ends the read with status 2 (timeout).
- R7: Outcome 1 (invalid reply) reissues only after INV_WAIT_CYC idle cycles. The second invalid reply ends the read with status 3.
- R8: Reply 2 (native defer) and reply 3 (I2C defer) each reissue at once. Each kind has its own counter with a limit of 6, and the seventh defer of a kind ends the read with status 2.
- R9: The native-defer counter clears on every ACK and on every I2C defer. The timeout and invalid-reply counters clear on every outcome 0. Timeouts do not clear the invalid-reply counter.
- R10: Outcome 3 or reply 4 (disconnect) ends the read at once with status 4.
- R11: Any outcome code above 3 or reply code above 4 ends the read with status 5 (unknown).
- R12: `busy` rises in the cycle after a request is accepted and stays high until `done`. Requests presented while busy are ignored.
- R13: During reset and after it, `busy`, `done` and `ch_req_valid` are low and `status` is 0. Reset in the middle of a read abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a read (taken only while idle) |
| req_i2c | input | 1 | 1 = I2C-over-AUX space, 0 = native space |
| req_mot | input | 1 | Hold the I2C bus open after the read |
| req_addr | input | ADDR_W | Request address (8-bit device address in I2C space) |
| req_len | input | LEN_W | Bytes to read |
| busy | output | 1 | Read in flight |
| ch_req_valid | output | 1 | One-cycle attempt strobe to the channel |
| ch_req_action | output | 2 | Attempt action code |
| ch_req_addr | output | ADDR_W | Formatted channel address |
| ch_req_offset | output | LEN_W | Byte offset of this attempt |
| ch_req_len | output | LEN_W | Bytes still to read |
| ch_rsp_valid | input | 1 | One-cycle channel answer strobe |
| ch_rsp_outcome | input | 3 | Channel outcome code |
| ch_rsp_reply | input | 3 | Reply code |
| ch_rsp_count | input | LEN_W | Bytes returned |
| done | output | 1 | One-cycle end-of-read pulse |
| status | output | 3 | Final status code |

## Verification
Scripted channel answer sequences are replayed against reads of several lengths in both address spaces.

- Sequences that stop exactly at a counter limit are paired with sequences that go one past it. This separates an off-by-one limit from a correct one.
- Mixed sequences interleave one failure class with another. Examples are defers split by an ACK or by an I2C defer, and timeouts split by a defer or an invalid reply. These show which events clear which counter.
- The cycle gap between consecutive attempts separates the invalid-reply pause from the immediate reissue of the other classes.
- Requests injected while busy, checked against the address of later attempts, show that a read cannot be hijacked.

// File: rtl/aux_rd_pkg.sv
// Shared codes and types of the AUX read sequencer.
package aux_rd_pkg;
    // channel outcome codes
    localparam logic [2:0] OC_OK      = 3'd0;
    localparam logic [2:0] OC_INVALID = 3'd1;
    localparam logic [2:0] OC_TIMEOUT = 3'd2;
    localparam logic [2:0] OC_HPD     = 3'd3;
    // reply codes
    localparam logic [2:0] RP_ACK     = 3'd0;
    localparam logic [2:0] RP_NACK    = 3'd1;
    localparam logic [2:0] RP_DEF_NAT = 3'd2;
    localparam logic [2:0] RP_DEF_I2C = 3'd3;
    localparam logic [2:0] RP_HPD     = 3'd4;
    // final status codes
    localparam logic [2:0] ST_SUCCESS = 3'd0;
    localparam logic [2:0] ST_NACK    = 3'd1;
    localparam logic [2:0] ST_TIMEOUT = 3'd2;
    localparam logic [2:0] ST_PROTO   = 3'd3;
    localparam logic [2:0] ST_HPD     = 3'd4;
    localparam logic [2:0] ST_UNKNOWN = 3'd5;
    // attempt actions
    localparam logic [1:0] ACT_NATIVE  = 2'd0;
    localparam logic [1:0] ACT_I2C     = 2'd1;
    localparam logic [1:0] ACT_I2C_MOT = 2'd2;
    // retry counter slots
    localparam int unsigned K_INV  = 0;
    localparam int unsigned K_TMO  = 1;
    localparam int unsigned K_DFN  = 2;
    localparam int unsigned K_DFI  = 3;
    localparam int unsigned K_SHRT = 4;
    localparam int unsigned NUM_K  = 5;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE} seq_state_t;
    typedef enum logic [1:0] {V_RETRY, V_PAUSE, V_FINISH} verdict_t;
endpackage

// File: rtl/aux_rd_addr_fmt.sv
// Forms the channel address and action from the latched request.
// Assumes an I2C request carries the 8-bit (read/write bit included) address.
module aux_rd_addr_fmt #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              is_i2c,
    input  logic              mot,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        action
);
    import aux_rd_pkg::*;

    // pick address shape and action code from the address space
    always_comb begin
        if (is_i2c) begin
            addr_out = addr_in >> 1;
            action   = mot ? ACT_I2C_MOT : ACT_I2C;
        end else begin
            addr_out = addr_in;
            action   = ACT_NATIVE;
        end
    end
endmodule

// File: rtl/aux_rd_retry_ctr.sv
// Retry counter for one failure class. Clear wins over increment.
// 'over' is high once the count has reached LIMIT, so one more event
// of the class takes it past the limit.
module aux_rd_retry_ctr #(
    parameter int unsigned LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic over
);
    localparam int unsigned W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    // count class events, saturating at the top code
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign over = (cnt >= LIM_V);
endmodule

// File: rtl/aux_rd_wait_timer.sv
// One-shot pause timer: after 'start', 'fin' rises in the CYCLES-th cycle.
// Assumes CYCLES >= 1.
module aux_rd_wait_timer #(
    parameter int unsigned CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fin
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          active;

    // load on start, count down to zero, then go quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(CYCLES - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign fin = active && (cnt == '0);
endmodule

// File: rtl/aux_rd_seq.sv
// AUX read retry sequencer top. Takes one read request while idle.
// Each attempt sends a one-cycle ch_req_valid, then waits for one
// ch_rsp_valid, sorts the answer and retries, pauses or finishes.
// Assumes the channel answers each attempt exactly once and never
// before the attempt strobe.
module aux_rd_seq #(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned LEN_W        = 8,
    parameter int unsigned INV_LIMIT    = 1,
    parameter int unsigned TMO_LIMIT    = 2,
    parameter int unsigned DEFER_LIMIT  = 6,
    parameter int unsigned SHORT_LIMIT  = 1,
    parameter int unsigned INV_WAIT_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_i2c,
    input  logic              req_mot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              ch_req_valid,
    output logic [1:0]        ch_req_action,
    output logic [ADDR_W-1:0] ch_req_addr,
    output logic [LEN_W-1:0]  ch_req_offset,
    output logic [LEN_W-1:0]  ch_req_len,
    input  logic              ch_rsp_valid,
    input  logic [2:0]        ch_rsp_outcome,
    input  logic [2:0]        ch_rsp_reply,
    input  logic [LEN_W-1:0]  ch_rsp_count,
    output logic              done,
    output logic [2:0]        status
);
    import aux_rd_pkg::*;

    localparam int unsigned LIMS [NUM_K] =
        '{INV_LIMIT, TMO_LIMIT, DEFER_LIMIT, DEFER_LIMIT, SHORT_LIMIT};

    seq_state_t        state;
    logic              lat_i2c, lat_mot;
    logic [ADDR_W-1:0] lat_addr;
    logic [LEN_W-1:0]  remaining, offset;
    logic              done_q;
    logic [2:0]        status_q;

    logic              accept, rsp_fire, tmr_fin;
    logic [NUM_K-1:0]  k_inc, k_clr, k_over;
    verdict_t          verdict;
    logic [2:0]        fin_status;
    logic              take_short;

    assign accept   = (state == S_IDLE) && req_valid;
    assign rsp_fire = (state == S_WAIT) && ch_rsp_valid;

    aux_rd_addr_fmt #(.ADDR_W(ADDR_W)) fmt_i (
        .is_i2c  (lat_i2c),
        .mot     (lat_mot),
        .addr_in (lat_addr),
        .addr_out(ch_req_addr),
        .action  (ch_req_action)
    );

    // one retry counter per failure class, cleared at the start of a read
    for (genvar k = 0; k < NUM_K; k++) begin : g_ctr
        aux_rd_retry_ctr #(.LIMIT(LIMS[k])) ctr_i (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (accept || (rsp_fire && k_clr[k])),
            .inc  (rsp_fire && k_inc[k]),
            .over (k_over[k])
        );
    end

    aux_rd_wait_timer #(.CYCLES(INV_WAIT_CYC)) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(rsp_fire && (verdict == V_PAUSE)),
        .fin  (tmr_fin)
    );

    // sort the channel answer into a verdict and counter updates
    always_comb begin
        k_inc      = '0;
        k_clr      = '0;
        verdict    = V_RETRY;
        fin_status = ST_SUCCESS;
        take_short = 1'b0;
        case (ch_rsp_outcome)
            OC_OK: begin
                if (ch_rsp_count > remaining) begin
                    verdict    = V_FINISH;
                    fin_status = ST_PROTO;
                end else begin
                    k_clr[K_TMO] = 1'b1;
                    k_clr[K_INV] = 1'b1;
                    case (ch_rsp_reply)
                        RP_ACK: begin
                            k_clr[K_DFN] = 1'b1;
                            if (ch_rsp_count == remaining) begin
                                verdict = V_FINISH;
                            end else begin
                                k_inc[K_SHRT] = 1'b1;
                                take_short    = 1'b1;
                                if (k_over[K_SHRT]) begin
                                    verdict    = V_FINISH;
                                    fin_status = ST_PROTO;
                                end
                            end
                        end
                        RP_NACK: begin
                            verdict    = V_FINISH;
                            fin_status = ST_NACK;
                        end
                        RP_DEF_NAT: begin
                            k_inc[K_DFN] = 1'b1;
                            if (k_over[K_DFN]) begin
                                verdict    = V_FINISH;
                                fin_status = ST_TIMEOUT;
                            end
                        end
                        RP_DEF_I2C: begin
                            k_clr[K_DFN] = 1'b1;
                            k_inc[K_DFI] = 1'b1;
                            if (k_over[K_DFI]) begin
                                verdict    = V_FINISH;
                                fin_status = ST_TIMEOUT;
                            end
                        end
                        RP_HPD: begin
                            verdict    = V_FINISH;
                            fin_status = ST_HPD;
                        end
                        default: begin
                            verdict    = V_FINISH;
                            fin_status = ST_UNKNOWN;
                        end
                    endcase
                end
            end
            OC_INVALID: begin
                k_inc[K_INV] = 1'b1;
                if (k_over[K_INV]) begin
                    verdict    = V_FINISH;
                    fin_status = ST_PROTO;
                end else begin
                    verdict = V_PAUSE;
                end
            end
            OC_TIMEOUT: begin
                k_inc[K_TMO] = 1'b1;
                if (k_over[K_TMO]) begin
                    verdict    = V_FINISH;
                    fin_status = ST_TIMEOUT;
                end
            end
            OC_HPD: begin
                verdict    = V_FINISH;
                fin_status = ST_HPD;
            end
            default: begin
                verdict    = V_FINISH;
                fin_status = ST_UNKNOWN;
            end
        endcase
    end

    // sequence attempts, track offset and remaining length, report result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            lat_i2c   <= 1'b0;
            lat_mot   <= 1'b0;
            lat_addr  <= '0;
            remaining <= '0;
            offset    <= '0;
            done_q    <= 1'b0;
            status_q  <= ST_SUCCESS;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        lat_i2c   <= req_i2c;
                        lat_mot   <= req_mot;
                        lat_addr  <= req_addr;
                        remaining <= req_len;
                        offset    <= '0;
                        state     <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (ch_rsp_valid) begin
                        if (take_short) begin
                            remaining <= remaining - ch_rsp_count;
                            offset    <= offset + ch_rsp_count;
                        end
                        case (verdict)
                            V_FINISH: begin
                                done_q   <= 1'b1;
                                status_q <= fin_status;
                                state    <= S_IDLE;
                            end
                            V_PAUSE: state <= S_PAUSE;
                            default: state <= S_ISSUE;
                        endcase
                    end
                end
                S_PAUSE: begin
                    if (tmr_fin) state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy          = (state != S_IDLE);
    assign ch_req_valid  = (state == S_ISSUE);
    assign ch_req_offset = offset;
    assign ch_req_len    = remaining;
    assign done          = done_q;
    assign status        = status_q;
endmodule

// File: rtl/aux_rd_seq_chk.sv
// Port-level checker for the AUX read sequencer, bound to the top.
module aux_rd_seq_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [2:0]        status,
    input logic              ch_req_valid,
    input logic [ADDR_W-1:0] ch_req_addr
);
    // R2: the end pulse lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a reported status is one of the six defined codes
    a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd5));

    // R12: an accepted request makes the block busy
    a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R12: the block is idle when it reports
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: attempts only go out during a read
    a_r12_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req_valid |-> busy);

    // R1: the channel address cannot change within a read
    a_r1_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_req_addr));

    // R13: reset leaves every strobe low
    a_r13_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !ch_req_valid));
endmodule

bind aux_rd_seq aux_rd_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .ch_req_valid(ch_req_valid),
    .ch_req_addr (ch_req_addr)
);

// File: tb/aux_rd_seq_tb_top.sv
`timescale 1ns/1ps
module aux_rd_seq_tb_top;
    localparam int AW  = 20;
    localparam int LW  = 8;
    localparam int WT  = 12;        // pause cycles used for the bench
    localparam int MAXR = 10;

    // codes from the requirements
    localparam logic [2:0] S_OK = 3'd0, S_NAK = 3'd1, S_TMO = 3'd2,
                           S_PRO = 3'd3, S_HPD = 3'd4, S_UNK = 3'd5;

    function automatic logic [13:0] rs(input logic [2:0] oc, input logic [2:0] rp,
                                       input logic [7:0] n);
        return {oc, rp, n};
    endfunction
    function automatic logic [13:0] ack(input logic [7:0] n);
        return rs(3'd0, 3'd0, n);
    endfunction
    localparam logic [13:0] Z   = 14'd0;
    localparam logic [13:0] NAK = {3'd0, 3'd1, 8'd0};
    localparam logic [13:0] DFN = {3'd0, 3'd2, 8'd0};
    localparam logic [13:0] DFI = {3'd0, 3'd3, 8'd0};
    localparam logic [13:0] HPR = {3'd0, 3'd4, 8'd0};
    localparam logic [13:0] UKR = {3'd0, 3'd6, 8'd0};
    localparam logic [13:0] INV = {3'd1, 3'd0, 8'd0};
    localparam logic [13:0] TMO = {3'd2, 3'd0, 8'd0};
    localparam logic [13:0] HPO = {3'd3, 3'd0, 8'd0};
    localparam logic [13:0] UKO = {3'd5, 3'd0, 8'd0};

    // answer i sits at bits [14*i +: 14]
    function automatic logic [139:0] sq(
        input logic [13:0] a0, input logic [13:0] a1 = Z, input logic [13:0] a2 = Z,
        input logic [13:0] a3 = Z, input logic [13:0] a4 = Z, input logic [13:0] a5 = Z,
        input logic [13:0] a6 = Z, input logic [13:0] a7 = Z, input logic [13:0] a8 = Z,
        input logic [13:0] a9 = Z);
        return {a9, a8, a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    typedef struct packed {
        logic           i2c;
        logic           mot;
        logic [AW-1:0]  addr;
        logic [7:0]     len;
        logic [139:0]   rsp;
        logic [2:0]     est;
        logic [7:0]     eiss;
        logic [7:0]     eoff;
        logic [7:0]     elen;
        logic [7:0]     egap;
        logic [AW-1:0]  eaddr;
        logic [1:0]     eact;
    } scen_t;

    localparam int NS = 21;
    localparam scen_t TBL [NS] = '{
        // R1 R2 native full ACK
        '{1'b0,1'b0,20'h00123,8'd4, sq(ack(4)),                S_OK, 8'd1,8'd0,8'd4,8'd0, 20'h00123,2'd0},
        // R1 I2C with hold flag
        '{1'b1,1'b1,20'h000A0,8'd3, sq(ack(3)),                S_OK, 8'd1,8'd0,8'd3,8'd0, 20'h00050,2'd2},
        // R1 R5 I2C plain, NACK
        '{1'b1,1'b0,20'h000A1,8'd2, sq(NAK),                   S_NAK,8'd1,8'd0,8'd2,8'd0, 20'h00050,2'd1},
        // R3 one short ACK then rest
        '{1'b0,1'b0,20'h00200,8'd8, sq(ack(3),ack(5)),         S_OK, 8'd2,8'd3,8'd5,8'd2, 20'h00200,2'd0},
        // R3 two short ACKs
        '{1'b0,1'b0,20'h00200,8'd8, sq(ack(2),ack(2)),         S_PRO,8'd2,8'd2,8'd6,8'd2, 20'h00200,2'd0},
        // R4 over-long count
        '{1'b0,1'b0,20'h00010,8'd2, sq(ack(3)),                S_PRO,8'd1,8'd0,8'd2,8'd0, 20'h00010,2'd0},
        // R6 two timeouts recover
        '{1'b0,1'b0,20'h00011,8'd4, sq(TMO,TMO,ack(4)),        S_OK, 8'd3,8'd0,8'd4,8'd2, 20'h00011,2'd0},
        // R6 third timeout fails
        '{1'b0,1'b0,20'h00011,8'd4, sq(TMO,TMO,TMO),           S_TMO,8'd3,8'd0,8'd4,8'd2, 20'h00011,2'd0},
        // R7 invalid then ACK with pause
        '{1'b0,1'b0,20'h00012,8'd4, sq(INV,ack(4)),            S_OK, 8'd2,8'd0,8'd4,8'(2+WT), 20'h00012,2'd0},
        // R7 second invalid fails
        '{1'b0,1'b0,20'h00012,8'd4, sq(INV,INV),               S_PRO,8'd2,8'd0,8'd4,8'(2+WT), 20'h00012,2'd0},
        // R8 six native defers recover
        '{1'b0,1'b0,20'h00013,8'd4, sq(DFN,DFN,DFN,DFN,DFN,DFN,ack(4)), S_OK,8'd7,8'd0,8'd4,8'd2, 20'h00013,2'd0},
        // R8 seventh native defer fails
        '{1'b0,1'b0,20'h00013,8'd4, sq(DFN,DFN,DFN,DFN,DFN,DFN,DFN),   S_TMO,8'd7,8'd0,8'd4,8'd2, 20'h00013,2'd0},
        // R8 seventh I2C defer fails
        '{1'b1,1'b0,20'h00040,8'd4, sq(DFI,DFI,DFI,DFI,DFI,DFI,DFI),   S_TMO,8'd7,8'd0,8'd4,8'd2, 20'h00020,2'd1},
        // R9 short ACK clears native defers
        '{1'b0,1'b0,20'h00014,8'd8, sq(DFN,DFN,DFN,DFN,ack(2),DFN,DFN,DFN,DFN,ack(6)), S_OK,8'd10,8'd2,8'd6,8'd2, 20'h00014,2'd0},
        // R9 I2C defer clears native defers
        '{1'b0,1'b0,20'h00015,8'd4, sq(DFN,DFN,DFN,DFN,DFN,DFI,DFN,DFN,ack(4)), S_OK,8'd9,8'd0,8'd4,8'd2, 20'h00015,2'd0},
        // R9 channel ok clears timeouts
        '{1'b0,1'b0,20'h00016,8'd4, sq(TMO,TMO,DFN,TMO,TMO,ack(4)),    S_OK,8'd6,8'd0,8'd4,8'd2, 20'h00016,2'd0},
        // R10 disconnect outcome
        '{1'b0,1'b0,20'h00017,8'd4, sq(HPO),                   S_HPD,8'd1,8'd0,8'd4,8'd0, 20'h00017,2'd0},
        // R10 disconnect reply
        '{1'b1,1'b1,20'h00018,8'd4, sq(HPR),                   S_HPD,8'd1,8'd0,8'd4,8'd0, 20'h0000C,2'd2},
        // R11 unknown outcome
        '{1'b0,1'b0,20'h00019,8'd4, sq(UKO),                   S_UNK,8'd1,8'd0,8'd4,8'd0, 20'h00019,2'd0},
        // R11 unknown reply
        '{1'b0,1'b0,20'h0001A,8'd4, sq(UKR),                   S_UNK,8'd1,8'd0,8'd4,8'd0, 20'h0001A,2'd0},
        // R9 timeouts leave the invalid count alone
        '{1'b0,1'b0,20'h0001B,8'd4, sq(INV,TMO,INV),           S_PRO,8'd3,8'd0,8'd4,8'd2, 20'h0001B,2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_i2c = 1'b0, req_mot = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          busy, ch_req_valid, done;
    logic [1:0]    ch_req_action;
    logic [AW-1:0] ch_req_addr;
    logic [LW-1:0] ch_req_offset, ch_req_len, ch_rsp_count = '0;
    logic          ch_rsp_valid = 1'b0;
    logic [2:0]    ch_rsp_outcome = '0, ch_rsp_reply = '0, status;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    aux_rd_seq #(.ADDR_W(AW), .LEN_W(LW), .INV_WAIT_CYC(WT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_i2c(req_i2c),
        .req_mot(req_mot), .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .ch_req_valid(ch_req_valid), .ch_req_action(ch_req_action),
        .ch_req_addr(ch_req_addr), .ch_req_offset(ch_req_offset),
        .ch_req_len(ch_req_len), .ch_rsp_valid(ch_rsp_valid),
        .ch_rsp_outcome(ch_rsp_outcome), .ch_rsp_reply(ch_rsp_reply),
        .ch_rsp_count(ch_rsp_count), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // drive one table entry and act as the channel
    task automatic run_scen(input int s);
        scen_t sc;
        int issues = 0, ridx = 0, last_cyc = 0, gap = 0, bad = 0, cyc = 0;
        bit pend = 1'b0, seen_done = 1'b0;
        logic [AW-1:0] a0 = '0;
        logic [1:0] act0 = '0;
        logic [7:0] loff = '0, llen = '0;
        logic [13:0] r;
        sc = TBL[s];
        req_i2c = sc.i2c; req_mot = sc.mot; req_addr = sc.addr; req_len = sc.len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R12 busy after accept", int'(busy), 1);
        while (cyc < 3000) begin
            if (done) begin
                seen_done = 1'b1;
                break;
            end
            if (ch_rsp_valid) ch_rsp_valid = 1'b0;
            if (ch_req_valid) begin
                issues++;
                if (issues == 1) begin
                    a0 = ch_req_addr; act0 = ch_req_action;
                end else if (ch_req_addr != a0) begin
                    bad++;
                end
                gap = cyc - last_cyc;
                last_cyc = cyc;
                loff = ch_req_offset; llen = ch_req_len;
                pend = 1'b1;
                // stray request while busy must be ignored
                req_valid = 1'b1; req_addr = ~sc.addr; req_i2c = ~sc.i2c; req_len = 8'hFF;
            end else if (pend) begin
                pend = 1'b0;
                req_valid = 1'b0;
                r = (ridx < MAXR) ? sc.rsp[14*ridx +: 14] : Z;
                ridx++;
                ch_rsp_outcome = r[13:11]; ch_rsp_reply = r[10:8]; ch_rsp_count = r[7:0];
                ch_rsp_valid = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(seen_done, $sformatf("R2 done seen scen %0d", s), int'(seen_done), 1);
        chk(status == sc.est, $sformatf("R2 status scen %0d", s), int'(status), int'(sc.est));
        chk(issues == int'(sc.eiss), $sformatf("R8 attempt count scen %0d", s), issues, int'(sc.eiss));
        chk(a0 == sc.eaddr, $sformatf("R1 address scen %0d", s), int'(a0), int'(sc.eaddr));
        chk(act0 == sc.eact, $sformatf("R1 action scen %0d", s), int'(act0), int'(sc.eact));
        chk(loff == sc.eoff, $sformatf("R3 last offset scen %0d", s), int'(loff), int'(sc.eoff));
        chk(llen == sc.elen, $sformatf("R3 last length scen %0d", s), int'(llen), int'(sc.elen));
        if (sc.egap != 0)
            chk(gap == int'(sc.egap), $sformatf("R7 attempt gap scen %0d", s), gap, int'(sc.egap));
        chk(bad == 0, $sformatf("R12 stray request scen %0d", s), bad, 0);
        @(negedge clk);
        chk(done == 1'b0, $sformatf("R2 single pulse scen %0d", s), int'(done), 0);
        chk(busy == 1'b0, $sformatf("R12 idle after done scen %0d", s), int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R13 reset state
        chk(busy == 1'b0, "R13 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R13 done in reset", int'(done), 0);
        chk(ch_req_valid == 1'b0, "R13 strobe in reset", int'(ch_req_valid), 0);
        chk(status == 3'd0, "R13 status in reset", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < NS; s++) run_scen(s);

        // R13 reset in the middle of a read
        req_i2c = 1'b0; req_mot = 1'b0; req_addr = 20'h00333; req_len = 8'd4;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R13 busy after mid-read reset", int'(busy), 0);
        @(negedge clk);
        chk(ch_req_valid == 1'b0, "R13 no attempt after reset", int'(ch_req_valid), 0);
        run_scen(0);
        finish_run();
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule